// File: doc/BRIEF.md
# Counter-Timed Serial Byte Transmitter

This block sends bytes on an asynchronous serial line. It runs on one clock per bit time. A host puts a byte on the data inputs and pulses an active-low write strobe. On the rising edge of that strobe the byte is stored in a hold register and a two-state holding machine moves from `HOLD_EMPTY` to `HOLD_FULL`. The strobe is first passed through a two-flop synchronizer into the bit-clock domain. The `ready` output is high while the machine is in `HOLD_EMPTY`.

A 4-bit frame counter normally rests at its top value, 15. This value means the line is idle or is sending the stop bit. When the counter is at 15 and the machine is in `HOLD_FULL`, one clock edge does two loads. The counter takes the value 6. A 16-bit shift register takes the framed word: a 0 start bit at the top, then the data bits least significant first, then ones in every lower position. On later edges the register shifts toward its top bit and takes in a 1 each time, and the counter steps up until it halts at 15 again. The serial output is the top bit of the shift register.

The counter's top bit falls from 1 to 0 when the counter is loaded. A registered copy of that bit detects the fall, and the fall fires the `HOLD_FULL` → `HOLD_EMPTY` transition. The host can then write the next byte while the current frame is still going out. The other transitions are `HOLD_EMPTY` → `HOLD_FULL` on a synchronized write edge, and `HOLD_FULL` → `HOLD_FULL` on a write edge, which replaces the held byte. If a write edge and a top-bit fall land in the same cycle, the write wins.

Top module: `ctr_uart_tx`

## Requirements
- R1: After synchronous reset, `txd` is 1 and `ready` is 1. Both stay unchanged for as long as no write edge arrives.
- R2: The write strobe is synchronized into the bit-clock domain, so `ready` drops to 0 after the third rising clock edge that follows the rising edge of `wr_n`. The byte on `din` is captured on that same edge.
- R3: A frame is one 0 start bit, then `din[0]` through `din[7]` in that order, then one 1 stop bit. Each bit lasts exactly one clock. The start bit appears on the clock edge right after the held byte becomes pending, if the line is idle.
- R4: The frame counter is loaded with 6 and steps up by one per clock until it halts at 15. A frame therefore lasts 10 clocks. After the frame, `txd` stays 1 because the shift register fills with ones.
- R5: The pending byte is released by the fall of the counter's top bit. `ready` returns to 1 one clock after the start bit begins.
- R6: A byte written after `ready` returns to 1 goes out directly after the current stop bit. The line has no idle clock between the two frames.
- R7: A second write edge while a byte is still pending replaces the held byte. Only the later byte is sent.
- R8: If a write edge and the release from R5 fall in the same cycle, the byte stays pending. `ready` stays 0, and the new byte follows the current frame without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one period per serial bit |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Byte to transmit, sampled on a write edge |
| wr_n | input | 1 | Active-low write strobe, asynchronous to `clk` |
| txd | output | 1 | Serial line, idles at 1 |
| ready | output | 1 | High when the hold register can take a byte |

## Verification
Two functions can land on the same clock edge: a synchronized write edge setting the pending state, and the counter's top-bit fall clearing it. The bench causes this by raising the strobe a second time exactly two clocks after the first. The second edge then reaches the holding machine on the edge right after the first frame's load. Correct behaviour is judged at the pins: `ready` must stay low through the first frame, and the second byte must begin on the clock right after the first frame's stop bit.

// File: rtl/uart_txc_pkg.sv
package uart_txc_pkg;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_t;

endpackage

// File: rtl/txc_strobe_sync.sv
module txc_strobe_sync (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic rise
);
    logic [2:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= 3'b111;
        else     pipe_q <= {pipe_q[1:0], strobe_n};
    end

    assign rise = pipe_q[1] & ~pipe_q[2];

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/txc_frame_counter.sv
module txc_frame_counter #(
    parameter int CNT_W    = 4,
    parameter int LOAD_VAL = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic tc,
    output logic msb
);
    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PRE  = CNT_W'(LOAD_VAL);

    logic [CNT_W-1:0] cnt_q;
    logic             ent;
    logic             step_en;

    assign ent     = 1'b1;
    assign tc      = ent & (cnt_q == TOP);
    assign step_en = ~tc;
    assign msb     = cnt_q[CNT_W-1];

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= TOP;
        else if (load)    cnt_q <= PRE;
        else if (step_en) cnt_q <= cnt_q + 1'b1;
    end

    assert_halt_at_top_R4: assert property (@(posedge clk) disable iff (rst)
        (tc && !load) |=> tc);
    assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
        (!tc && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/txc_frame_shifter.sv
module txc_frame_shifter #(
    parameter int SR_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              sout
);
    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] frame;

    always_comb begin
        frame           = '1;
        frame[SR_W-1]   = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            frame[SR_W-2-i] = data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       sr_q <= '1;
        else if (load) sr_q <= frame;
        else           sr_q <= {sr_q[SR_W-2:0], 1'b1};
    end

    assign sout = sr_q[SR_W-1];

    assert_start_bit_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> !sout);
    assert_fill_ones_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> sr_q[0]);
endmodule

// File: rtl/ctr_uart_tx.sv
module ctr_uart_tx #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int SR_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    output logic              txd,
    output logic              ready
);
    import uart_txc_pkg::*;

    localparam int LOAD_VAL = (2 ** CNT_W) - (DATA_W + 2);

    hold_state_t       state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic              wr_rise;
    logic              tc;
    logic              msb;
    logic              msb_q;
    logic              msb_fall;
    logic              pending;
    logic              load;

    txc_strobe_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (wr_n),
        .rise     (wr_rise)
    );

    txc_frame_counter #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (LOAD_VAL)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .tc   (tc),
        .msb  (msb)
    );

    txc_frame_shifter #(
        .SR_W   (SR_W),
        .DATA_W (DATA_W)
    ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .data (hold_q),
        .sout (txd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            msb_q  <= 1'b1;
        end else begin
            msb_q <= msb;
            if (wr_rise) hold_q <= din;
        end
    end

    assign msb_fall = msb_q & ~msb;

    always_ff @(posedge clk) begin
        if (rst) state_q <= HOLD_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: if (wr_rise) state_d = HOLD_FULL;
            HOLD_FULL: begin
                if (wr_rise)       state_d = HOLD_FULL;
                else if (msb_fall) state_d = HOLD_EMPTY;
            end
        endcase
    end

    always_comb begin
        pending = (state_q == HOLD_FULL);
        ready   = ~pending;
        load    = tc & pending;
    end

    assert_write_takes_R2: assert property (@(posedge clk) disable iff (rst)
        wr_rise |=> !ready);
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (msb_fall && !wr_rise) |=> ready);
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (msb_fall && wr_rise) |=> !ready);
    assert_idle_line_R1: assert property (@(posedge clk) disable iff (rst)
        (tc && $past(tc) && !$past(load)) |-> txd);
endmodule

// File: tb/sim_ctr_uart_tx.sv
module sim_ctr_uart_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic       wr_n = 1'b1;
    logic       txd;
    logic       ready;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    ctr_uart_tx u0 (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .wr_n  (wr_n),
        .txd   (txd),
        .ready (ready)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        @(negedge clk); din = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
    endtask

    // called in the start-bit cycle; returns in the stop-bit cycle
    task automatic expect_frame(input logic [7:0] d, input logic rdy_exp);
        chk(txd, 1'b0, "R3 start bit");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 0) chk(ready, rdy_exp, "R5/R8 ready after load");
            chk(txd, d[i], "R3 data bit");
        end
        @(negedge clk);
        chk(txd, 1'b1, "R4 stop bit");
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(txd, 1'b1, "R1 txd at reset");
        chk(ready, 1'b1, "R1 ready at reset");
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(txd & ready, 1'b1, "R1 idle hold");
        end
    endtask

    task automatic t_single(input logic [7:0] d);
        pulse_wr(d);
        repeat (2) @(negedge clk);
        chk(ready, 1'b1, "R2 no early capture");
        @(negedge clk);
        chk(ready, 1'b0, "R2 ready drops");
        @(negedge clk);
        expect_frame(d, 1'b1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(txd, 1'b1, "R4 idle after frame");
        end
        chk(ready, 1'b1, "R5 ready idle");
    endtask

    task automatic t_back_to_back(input logic [7:0] a, input logic [7:0] b);
        fork
            begin
                pulse_wr(a);
                repeat (4) @(negedge clk);
                expect_frame(a, 1'b1);
                @(negedge clk);
                expect_frame(b, 1'b1);
                @(negedge clk);
                chk(txd, 1'b1, "R6 idle after second");
            end
            begin
                wait (ready == 1'b0);
                wait (ready == 1'b1);
                pulse_wr(b);
            end
        join
        repeat (4) @(negedge clk);
    endtask

    task automatic t_overwrite(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
        fork
            begin
                pulse_wr(c);
                repeat (4) @(negedge clk);
                expect_frame(c, 1'b1);
                @(negedge clk);
                expect_frame(b, 1'b1);
                @(negedge clk);
                chk(txd, 1'b1, "R7 only later byte sent");
            end
            begin
                wait (ready == 1'b0);
                wait (ready == 1'b1);
                pulse_wr(a);
                repeat (2) @(negedge clk);
                pulse_wr(b);
            end
        join
        repeat (4) @(negedge clk);
    endtask

    task automatic t_collision(input logic [7:0] a, input logic [7:0] b);
        pulse_wr(a);
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); din = b;
        chk(ready, 1'b0, "R8 pending before load");
        @(negedge clk);
        expect_frame(a, 1'b0);
        @(negedge clk);
        expect_frame(b, 1'b1);
        repeat (4) @(negedge clk);
        chk(txd, 1'b1, "R8 idle after pair");
    endtask

    initial begin
        t_reset();
        t_single(8'hA5);
        t_single(8'h01);
        t_back_to_back(8'h3C, 8'hC3);
        t_overwrite(8'h0F, 8'h55, 8'h96);
        t_collision(8'h81, 8'h7E);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule